// File: doc/BRIEF.md
# Instruction Cycle Sequencer with Interrupt Entry and Return

This block is the control core of a small accumulator processor. It moves through three stages in a fixed loop: it fetches a word from memory into an instruction register, it carries out that instruction, and it then spends one cycle on a dedicated interrupt check. A program counter selects the fetch address and advances by one on every completed fetch. The block has one accumulator. Load, add and store move data between the accumulator and memory. A jump replaces the program counter. A return-from-interrupt opcode ends a handler.

Memory is reached through a single request channel that uses valid/ready handshakes. Reads and writes share this channel. Read data is taken in the same cycle that the handshake completes. Peripheral registers sit in the same address space, so I/O transfers are ordinary loads and stores.

An interrupt request line is looked at only in the check stage. If the request is accepted, the block saves the program counter and the interrupt-enable flag into a context register. It then clears the enable flag and continues at a fixed handler address. The return opcode copies the saved values back into the program counter and the enable flag.

Top module: `isq_seq`

## Requirements
- R1: While reset is held and right after it is released, `stage` is 0 (fetch), `pc` is RESET_PC (default 0), `ir` and `acc` are 0, `irq_en` is 1 and `irq_ack` is 0.
- R2: In the fetch stage (`stage`=0) the block makes a read request (`mem_req_we`=0) at `pc`. On the cycle the handshake completes, `ir` takes `mem_rsp_data`, `pc` increases by one modulo 2^ADDR_W, and `stage` becomes 1 (execute).
- R3: Back-pressure: once `mem_req_valid` is high, it stays high, and `mem_req_addr`, `mem_req_we` and `mem_req_wdata` hold their values, until a cycle in which `mem_req_ready` is high. The stage does not advance while the block waits.
- R4: Instruction format: the opcode is in bits [15:12] and the operand address is in bits [11:0]. Opcode 1 is load, 2 is add, 3 is store, 4 is jump and 5 is return. Every other opcode does nothing in execute and goes on to the check stage.
- R5: Load and add make a read request at the operand address. On the handshake, load sets `acc` to the read word, and add sets `acc` to `acc` plus the read word, modulo 2^DATA_W.
- R6: Store makes a write request (`mem_req_we`=1) at the operand address with `mem_req_wdata` equal to `acc`. Store leaves `acc` unchanged.
- R7: Jump makes no memory request. It spends one cycle in execute and loads `pc` with the operand address. The words after the jump are not executed.
- R8: Every execute is followed by exactly one cycle in the check stage (`stage`=2), and then by fetch. If no interrupt is accepted, `pc` and `irq_en` are unchanged across the check stage.
- R9: In the check stage, if `irq` and `irq_en` are both 1, then `irq_ack` is 1 for that cycle. The context register saves `pc` and `irq_en`, `pc` becomes HANDLER_PC (default 0x100), and `irq_en` becomes 0.
- R10: While `irq_en` is 0, a held `irq` is not accepted. It is accepted at the first check stage after a return has set the enable flag again.
- R11: Return restores `pc` and `irq_en` from the context register. The interrupted program then continues at the saved address.
- R12: `irq` is sampled only in the check stage. A pulse that starts and ends within fetch and execute has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_req_valid | output | 1 | Memory request is valid |
| mem_req_ready | input | 1 | Memory accepts the request this cycle |
| mem_req_we | output | 1 | 1 = write, 0 = read |
| mem_req_addr | output | ADDR_W | Request address |
| mem_req_wdata | output | DATA_W | Write data (the accumulator) |
| mem_rsp_data | input | DATA_W | Read data, valid in the handshake cycle |
| irq | input | 1 | Level interrupt request |
| irq_ack | output | 1 | Interrupt accepted this cycle |
| irq_en | output | 1 | Interrupt-enable flag |
| stage | output | 2 | 0 fetch, 1 execute, 2 interrupt check |
| pc | output | ADDR_W | Program counter |
| ir | output | DATA_W | Instruction register |
| acc | output | DATA_W | Accumulator |

## Verification
Stalls are inserted on an irregular pattern. If the design advanced a stage or changed a request field without a handshake, the result would diverge from the per-cycle model. One add overflows, so an accumulator that is too narrow or saturates would leave a wrong value in memory. The interrupt line is held high across a whole handler: a design that ignored the cleared enable flag would re-enter the handler before the handler's store. A design that failed to restore the flag on return would never take the second request, and one that restored the wrong address would leave the idle loop. A short interrupt pulse that ends before the check stage would produce an acknowledge if the line were sampled in the wrong stage.

// File: rtl/isq_pkg.sv
package isq_pkg;
  localparam int OPC_W = 4;

  typedef enum logic [1:0] {
    ST_FETCH = 2'd0,
    ST_EXEC  = 2'd1,
    ST_ICHK  = 2'd2
  } stage_e;

  typedef enum logic [OPC_W-1:0] {
    OPC_NOP   = 4'd0,
    OPC_LOAD  = 4'd1,
    OPC_ADD   = 4'd2,
    OPC_STORE = 4'd3,
    OPC_JUMP  = 4'd4,
    OPC_RETI  = 4'd5
  } opc_e;

  typedef struct packed {
    logic mem_rd;
    logic do_add;
    logic mem_wr;
    logic jump;
    logic reti;
  } dec_t;
endpackage

// File: rtl/isq_decode.sv
module isq_decode
  import isq_pkg::*;
(
  input  logic [OPC_W-1:0] opcode,
  output dec_t             dec
);
  // R4: opcode classes; unknown codes decode to no action
  always_comb begin
    dec = '0;
    case (opcode)
      OPC_LOAD:  dec.mem_rd = 1'b1;
      OPC_ADD: begin
        dec.mem_rd = 1'b1;
        dec.do_add = 1'b1;
      end
      OPC_STORE: dec.mem_wr = 1'b1;
      OPC_JUMP:  dec.jump   = 1'b1;
      OPC_RETI:  dec.reti   = 1'b1;
      default:   dec = '0;
    endcase
  end
endmodule

// File: rtl/isq_accum.sv
module isq_accum #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  logic              add_en,
  input  logic [DATA_W-1:0] operand,
  output logic [DATA_W-1:0] acc
);
  always_ff @(posedge clk) begin
    if (!rst_n)       acc <= '0;
    else if (load_en) acc <= operand;
    else if (add_en)  acc <= acc + operand;
  end

  // R5: add wraps modulo 2^DATA_W
  a_r5_add_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    add_en |=> acc == DATA_W'($past(acc) + $past(operand)));

  // R6: without a load or add the accumulator holds
  a_r6_acc_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_en && !add_en) |=> $stable(acc));
endmodule

// File: rtl/isq_ctx.sv
module isq_ctx #(
  parameter int                ADDR_W     = 12,
  parameter logic [ADDR_W-1:0] RESET_ADDR = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              save,
  input  logic [ADDR_W-1:0] pc_in,
  input  logic              ie_in,
  output logic [ADDR_W-1:0] ctx_pc,
  output logic              ctx_ie
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctx_pc <= RESET_ADDR;
      ctx_ie <= 1'b1;
    end else if (save) begin
      ctx_pc <= pc_in;
      ctx_ie <= ie_in;
    end
  end

  // R9: accepted interrupt captures pc and enable flag
  a_r9_ctx_capture: assert property (@(posedge clk) disable iff (!rst_n)
    save |=> (ctx_pc == $past(pc_in)) && (ctx_ie == $past(ie_in)));

  // R11: context is kept until the next accepted interrupt
  a_r11_ctx_keep: assert property (@(posedge clk) disable iff (!rst_n)
    !save |=> $stable(ctx_pc) && $stable(ctx_ie));
endmodule

// File: rtl/isq_seq.sv
module isq_seq
  import isq_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int ADDR_W     = 12,
  parameter int RESET_PC   = 0,
  parameter int HANDLER_PC = 'h100
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_we,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [DATA_W-1:0] mem_req_wdata,
  input  logic [DATA_W-1:0] mem_rsp_data,
  input  logic              irq,
  output logic              irq_ack,
  output logic              irq_en,
  output logic [1:0]        stage,
  output logic [ADDR_W-1:0] pc,
  output logic [DATA_W-1:0] ir,
  output logic [DATA_W-1:0] acc
);
  localparam logic [ADDR_W-1:0] RESET_ADDR = ADDR_W'(RESET_PC);
  localparam logic [ADDR_W-1:0] VEC_ADDR   = ADDR_W'(HANDLER_PC);
  localparam logic [ADDR_W-1:0] PC_STEP    = ADDR_W'(1);

  stage_e            state_q, state_d;
  logic [ADDR_W-1:0] pc_q, pc_d;
  logic [DATA_W-1:0] ir_q;
  logic              ie_q, ie_d;
  dec_t              dec;
  logic [ADDR_W-1:0] opnd;
  logic              mem_op, hs, fetch_hs, exec_hs, accept;
  logic [ADDR_W-1:0] ctx_pc;
  logic              ctx_ie;
  logic [DATA_W-1:0] acc_q;

  isq_decode u_dec (
    .opcode (ir_q[DATA_W-1 -: OPC_W]),
    .dec    (dec)
  );

  assign opnd   = ir_q[ADDR_W-1:0];
  assign mem_op = dec.mem_rd | dec.mem_wr;

  // request channel, driven from registered state only
  always_comb begin
    mem_req_valid = 1'b0;
    mem_req_we    = 1'b0;
    mem_req_addr  = pc_q;
    mem_req_wdata = acc_q;
    if (state_q == ST_FETCH) begin
      mem_req_valid = 1'b1;
    end else if (state_q == ST_EXEC && mem_op) begin
      mem_req_valid = 1'b1;
      mem_req_we    = dec.mem_wr;
      mem_req_addr  = opnd;
    end
  end

  assign hs       = mem_req_valid & mem_req_ready;
  assign fetch_hs = (state_q == ST_FETCH) & hs;
  assign exec_hs  = (state_q == ST_EXEC) & hs;
  assign accept   = (state_q == ST_ICHK) & irq & ie_q;

  always_comb begin
    state_d = state_q;
    pc_d    = pc_q;
    ie_d    = ie_q;
    unique case (state_q)
      ST_FETCH: begin
        if (hs) begin
          state_d = ST_EXEC;
          pc_d    = pc_q + PC_STEP;
        end
      end
      ST_EXEC: begin
        if (!mem_op || hs) state_d = ST_ICHK;
        if (dec.jump) pc_d = opnd;
        if (dec.reti) begin
          pc_d = ctx_pc;
          ie_d = ctx_ie;
        end
      end
      ST_ICHK: begin
        state_d = ST_FETCH;
        if (accept) begin
          pc_d = VEC_ADDR;
          ie_d = 1'b0;
        end
      end
      default: state_d = ST_FETCH;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_FETCH;
      pc_q    <= RESET_ADDR;
      ir_q    <= '0;
      ie_q    <= 1'b1;
    end else begin
      state_q <= state_d;
      pc_q    <= pc_d;
      ie_q    <= ie_d;
      if (fetch_hs) ir_q <= mem_rsp_data;
    end
  end

  isq_ctx #(
    .ADDR_W     (ADDR_W),
    .RESET_ADDR (RESET_ADDR)
  ) u_ctx (
    .clk    (clk),
    .rst_n  (rst_n),
    .save   (accept),
    .pc_in  (pc_q),
    .ie_in  (ie_q),
    .ctx_pc (ctx_pc),
    .ctx_ie (ctx_ie)
  );

  isq_accum #(
    .DATA_W (DATA_W)
  ) u_acc (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_en (exec_hs & dec.mem_rd & ~dec.do_add),
    .add_en  (exec_hs & dec.do_add),
    .operand (mem_rsp_data),
    .acc     (acc_q)
  );

  assign irq_ack = accept;
  assign irq_en  = ie_q;
  assign stage   = state_q;
  assign pc      = pc_q;
  assign ir      = ir_q;
  assign acc     = acc_q;

  // R2: completed fetch advances pc and enters execute
  a_r2_fetch_step: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_FETCH && hs) |=> (pc_q == $past(pc_q) + PC_STEP) && (state_q == ST_EXEC));

  // R3: a stalled request holds all its fields
  a_r3_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> mem_req_valid && $stable(mem_req_addr)
      && $stable(mem_req_we) && $stable(mem_req_wdata));

  // R7: jump lands on its operand and goes to the check stage
  a_r7_jump_target: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_EXEC && dec.jump) |=> (pc_q == $past(opnd)) && (state_q == ST_ICHK));

  // R8: the check stage lasts one cycle
  a_r8_check_once: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ICHK) |=> (state_q == ST_FETCH));

  // R8: no acceptance leaves pc and enable untouched
  a_r8_check_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ICHK && !(irq && ie_q)) |=> $stable(pc_q) && $stable(ie_q));

  // R9: acceptance vectors to the handler with interrupts masked
  a_r9_vector: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ICHK && irq && ie_q) |=> (pc_q == VEC_ADDR) && !ie_q);

  // R11: return takes pc and enable from the context
  a_r11_restore: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_EXEC && dec.reti) |=> (pc_q == $past(ctx_pc)) && (ie_q == $past(ctx_ie)));
endmodule

// File: tb/isq_seq_tb.sv
module isq_seq_tb;
  localparam int AW = 12;
  localparam int DW = 16;
  localparam int VEC = 'h100;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          mem_req_valid, mem_req_we, irq_ack, irq_en;
  logic          mem_req_ready = 1'b0;
  logic          irq = 1'b0;
  logic [AW-1:0] mem_req_addr, pc;
  logic [DW-1:0] mem_req_wdata, ir, acc;
  logic [DW-1:0] mem_rsp_data = '0;
  logic [1:0]    stage;

  always #4 clk = ~clk;

  isq_seq u_dut (
    .clk(clk), .rst_n(rst_n),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_we(mem_req_we), .mem_req_addr(mem_req_addr),
    .mem_req_wdata(mem_req_wdata), .mem_rsp_data(mem_rsp_data),
    .irq(irq), .irq_ack(irq_ack), .irq_en(irq_en), .stage(stage),
    .pc(pc), .ir(ir), .acc(acc)
  );

  int n_cmp = 0;
  int n_bad = 0;
  int acks  = 0;
  int cyc   = 0;
  logic [DW-1:0] mem [int];

  function automatic logic [DW-1:0] rd(input int a);
    return mem.exists(a) ? mem[a] : '0;
  endfunction

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // behavioural reference state
  int            m_stage;
  logic [AW-1:0] m_pc, m_cpc;
  logic [DW-1:0] m_ir, m_acc;
  logic          m_ie, m_cie;

  always @(posedge clk) begin
    logic [3:0]    op;
    logic [AW-1:0] a;
    if (!rst_n) begin
      m_stage = 0; m_pc = '0; m_cpc = '0; m_ir = '0; m_acc = '0; m_ie = 1'b1; m_cie = 1'b1;
    end else begin
      op = m_ir[15:12];
      a  = m_ir[AW-1:0];
      case (m_stage)
        0: if (mem_req_ready) begin
             m_ir = rd(int'(m_pc)); m_pc = m_pc + 1'b1; m_stage = 1;
           end
        1: begin
             if (op == 1 || op == 2 || op == 3) begin
               if (mem_req_ready) begin
                 if (op == 1) m_acc = rd(int'(a));
                 else if (op == 2) m_acc = m_acc + rd(int'(a));
                 else mem[int'(a)] = m_acc;
                 m_stage = 2;
               end
             end else begin
               if (op == 4) m_pc = a;
               if (op == 5) begin m_pc = m_cpc; m_ie = m_cie; end
               m_stage = 2;
             end
           end
        default: begin
             if (irq && m_ie) begin
               m_cpc = m_pc; m_cie = m_ie; m_ie = 1'b0; m_pc = AW'(VEC);
             end
             m_stage = 0;
           end
      endcase
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    logic [3:0] op;
    logic       e_valid, e_we, e_ack;
    logic [AW-1:0] e_addr;
    if (rst_n) begin
      op      = m_ir[15:12];
      e_valid = (m_stage == 0) || (m_stage == 1 && (op == 1 || op == 2 || op == 3));
      e_we    = (m_stage == 1) && (op == 3);
      e_addr  = (m_stage == 0) ? m_pc : m_ir[AW-1:0];
      e_ack   = (m_stage == 2) && irq && m_ie;
      chk("R8", "stage", stage, m_stage);
      chk("R2", "pc", pc, m_pc);
      chk("R2", "ir", ir, m_ir);
      chk("R5", "acc", acc, m_acc);
      chk("R9", "irq_en", irq_en, m_ie);
      chk("R3", "req_valid", mem_req_valid, e_valid);
      if (e_valid) chk("R3", "req_addr", mem_req_addr, e_addr);
      if (e_valid) chk("R6", "req_we", mem_req_we, e_we);
      if (e_we) chk("R6", "req_wdata", mem_req_wdata, m_acc);
      chk("R9", "irq_ack", irq_ack, e_ack);
      if (irq_ack) acks++;
    end
  end

  // memory responder with irregular stalls
  always @(negedge clk) begin
    #1;
    cyc++;
    mem_req_ready = ((cyc % 4) != 1) && ((cyc % 7) != 3);
    mem_rsp_data  = rd(int'(mem_req_addr));
  end

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL R8 watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    mem[0]  = 16'h1080; mem[1] = 16'h2081; mem[2] = 16'h3082; mem[3] = 16'h7000;
    mem[4]  = 16'h2081; mem[5] = 16'h4008; mem[6] = 16'h3083; mem[7] = 16'h3083;
    mem[8]  = 16'h3084; mem[9] = 16'h4009;
    mem['h100] = 16'h1090; mem['h101] = 16'h3091; mem['h102] = 16'h5000;
    mem['h80] = 16'h0005; mem['h81] = 16'hFFFE; mem['h90] = 16'h00AA;

    repeat (3) @(negedge clk);
    chk("R1", "reset stage", stage, 0);
    chk("R1", "reset pc", pc, 0);
    chk("R1", "reset acc", acc, 0);
    chk("R1", "reset ir", ir, 0);
    chk("R1", "reset irq_en", irq_en, 1);
    chk("R1", "reset irq_ack", irq_ack, 0);
    #1 rst_n = 1'b1;

    // main program, no interrupts
    repeat (150) @(negedge clk);
    #2;
    chk("R5", "overflowing sum stored", rd('h82), 16'h0003);
    chk("R6", "store after nop", rd('h84), 16'h0001);
    chk("R4", "undefined opcode left acc alone", rd('h84), 16'h0001);
    chk("R7", "skipped store untouched", mem.exists('h83), 0);
    chk("R7", "pc in jump loop", (pc == 9 || pc == 10), 1);
    chk("R8", "no acks without irq", acks, 0);

    // short pulse confined to fetch/execute
    do begin @(negedge clk); #2; end while (stage != 2'd0);
    irq = 1'b1;
    @(negedge clk); #2;
    irq = 1'b0;
    repeat (40) @(negedge clk);
    #2;
    chk("R12", "pulse outside check stage ignored", acks, 0);
    chk("R12", "pc still in loop", (pc == 9 || pc == 10), 1);

    // held request, masked during handler
    irq = 1'b1;
    for (int k = 0; k < 60 && acks < 1; k++) begin @(negedge clk); #2; end
    chk("R9", "first acceptance", acks, 1);
    @(negedge clk); #2;
    chk("R9", "pc at handler", pc, VEC);
    chk("R9", "enable cleared", irq_en, 0);
    for (int k = 0; k < 100 && acks < 2; k++) begin @(negedge clk); #2; end
    chk("R10", "held request re-accepted after return", acks, 2);
    chk("R10", "handler store done before re-entry", rd('h91), 16'h00AA);
    chk("R11", "restored pc at check", pc, 9);
    chk("R11", "restored enable", irq_en, 1);
    irq = 1'b0;
    repeat (60) @(negedge clk);
    #2;
    chk("R11", "resumed in loop", (pc == 9 || pc == 10), 1);
    chk("R11", "enable after final return", irq_en, 1);
    chk("R11", "no extra acceptance", acks, 2);
    finish_run();
  end
endmodule